// File: doc/BRIEF.md
# Reloadable Interval Timer with Timestamp

This block is a register-mapped timer peripheral. It has a free-running timestamp counter and two independent down-counting interval timers. Each interval timer takes its settings from one reload word. The two lowest bits of that word are control flags: an enable flag and a one-shot flag. The remaining bits hold the reload count, whose two lowest count bits are therefore always zero. When a timer runs out it raises a pending flag. When the timestamp wraps to zero it raises its own pending flag. All three flags sit in one status word, are cleared by writing 1 to them, and drive one interrupt line each.

The register bus is single-cycle. A write takes effect on the clock edge at which `bus_we` is sampled high. Read data is a combinational function of `bus_addr`, and a read has no side effects. Software typically uses the timers in one of two ways. It can program a periodic tick once. Or it can run a timer in one-shot mode and rewrite the count field before each expiry, keeping the two flag bits as they are.

Each interval timer is built around a three-state machine:

- **IDLE**: the timer is stopped and its value is frozen.
- **PERIODIC**: the timer is counting and reloads when it runs out.
- **ONESHOT**: the timer is counting and stops when it runs out.

The transitions are:

- **start**: IDLE to PERIODIC or ONESHOT. It happens on a reload write with the enable flag set, and the mode is chosen by the one-shot flag.
- **stop**: PERIODIC or ONESHOT to IDLE. It happens on a reload write with the enable flag clear.
- **remode**: PERIODIC to ONESHOT, or the reverse. It happens on a reload write with the enable flag set and the other mode flag.
- **expire-stop**: ONESHOT to IDLE. It happens when the value is zero and no reload write occurs in that cycle.

A periodic expiry keeps the timer in PERIODIC.

Top module: `stamp_interval_timer`

## Requirements
- R1: The timestamp increments by one on every clock in which it is not written. A write to byte offset 0x00 loads the timestamp from the low bits of the write data, so writing 0 resets it. Reads return the timestamp zero-extended.
- R2: When the timestamp passes from all ones to zero, status bit 2 is set.
- R3: A reload word (timer 1 at 0x08, timer 2 at 0x10) has the enable flag in bit 0 and the one-shot flag in bit 1. Its count field sits in bits CNT_W-1:2, with the two low count bits taken as zero. Reading the reload word returns the stored count and one-shot flag, bit 0 showing whether the timer is running, and zeros above bit CNT_W-1.
- R4: A start loads the value (timer 1 at 0x04, timer 2 at 0x0C) with the reload count. A running timer decrements its value once per clock. A running timer whose value is zero expires on that clock and sets its pending bit (timer 1 in bit 0, timer 2 in bit 1), so the expiry interval is count+1 clocks.
- R5: In PERIODIC, an expiry reloads the value from the reload count, and the timer keeps running.
- R6: In ONESHOT, an expiry moves the timer to IDLE. Bit 0 of the reload word then reads 0, bit 1 stays 1, and the value stays at zero with no further expiries.
- R7: A reload write that keeps the timer running does not disturb the current value. The new count is used from the next reload on.
- R8: A reload write with bit 0 clear, including a write of zero, stops the timer and freezes its value.
- R9: The status word is at 0x20. Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If a flag is set and cleared on the same clock, the set wins.
- R10: `irq_tmr1`, `irq_tmr2` and `irq_stamp` are equal to status bits 0, 1 and 2.
- R11: Value registers are read-only: writes to them are ignored. Reads of any other offset, misaligned ones included, return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_tmr1 | output | 1 | Timer 1 pending |
| irq_tmr2 | output | 1 | Timer 2 pending |
| irq_stamp | output | 1 | Timestamp wrap pending |

## Verification
The bench builds the block with CNT_W = 16 and TS_W = 8. At TS_W = 8 the timestamp wraps every 256 clocks, so the wrap flag can be reached directly and checked at the exact clock where it appears. The 16-bit count width keeps the readback of the reload word and the zero-extension above bit 15 observable, while periods stay short. Short reload counts of 0, 4, 8 and 20 make the count+1 interval, the periodic reload, the one-shot stop, a mid-count rewrite and the set-over-clear collision all cycle-exact.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PERIODIC = 2'd1,
        ST_ONESHOT  = 2'd2
    } tmr_state_e;

    localparam int NUM_TMR = 2;
    localparam int PEND_W  = NUM_TMR + 1;
    localparam int PEND_TS = NUM_TMR;

    // byte offsets; timer n registers sit 8 bytes after timer n-1
    localparam int OFS_TS       = 'h00;
    localparam int OFS_T1_CUR   = 'h04;
    localparam int OFS_T1_RLD   = 'h08;
    localparam int OFS_TMR_STEP = 'h08;
    localparam int OFS_STATUS   = 'h20;

endpackage

// File: rtl/ivt_downcounter.sv
module ivt_downcounter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_we,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cur_o,
    output logic [CNT_W-1:0] rld_cnt_o,
    output logic [31:0]      rld_word_o,
    output tmr_state_e       state_o,
    output logic             expire_o
);
    localparam int FIELD_W = CNT_W - 2;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_e         state_q, state_d;
    logic [FIELD_W-1:0] field_q;
    logic               osh_q;
    logic [CNT_W-1:0]   cur_q, cur_d;
    logic               wr_en, wr_osh, running, at_zero;
    logic [CNT_W-1:0]   wr_cnt, rld_cnt;

    assign wr_en   = wdata[0];
    assign wr_osh  = wdata[1];
    assign wr_cnt  = {wdata[CNT_W-1:2], 2'b00};
    assign rld_cnt = {field_q, 2'b00};
    assign running = (state_q != ST_IDLE);
    assign at_zero = (cur_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rld_we && wr_en)
                    state_d = wr_osh ? ST_ONESHOT : ST_PERIODIC;
            end
            ST_PERIODIC: begin
                if (rld_we)
                    state_d = !wr_en ? ST_IDLE : (wr_osh ? ST_ONESHOT : ST_PERIODIC);
            end
            ST_ONESHOT: begin
                if (rld_we)
                    state_d = !wr_en ? ST_IDLE : (wr_osh ? ST_ONESHOT : ST_PERIODIC);
                else if (at_zero)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // value datapath
    always_comb begin
        cur_d = cur_q;
        if (!running) begin
            if (state_d != ST_IDLE)
                cur_d = wr_cnt;
        end else if (at_zero) begin
            cur_d = (state_q == ST_PERIODIC) ? rld_cnt : '0;
        end else begin
            cur_d = cur_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= '0;
            osh_q   <= 1'b0;
            cur_q   <= '0;
        end else begin
            cur_q <= cur_d;
            if (rld_we) begin
                field_q <= wdata[CNT_W-1:2];
                osh_q   <= wr_osh;
            end
        end
    end

    // outputs
    always_comb begin
        rld_word_o             = '0;
        rld_word_o[CNT_W-1:0]  = {field_q, osh_q, running};
        cur_o                  = cur_q;
        rld_cnt_o              = rld_cnt;
        state_o                = state_q;
        expire_o               = running && at_zero;
    end

endmodule

// File: rtl/ivt_stamp.sv
module ivt_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [TS_W-1:0] wdata,
    output logic [TS_W-1:0] ts_o,
    output logic            wrap_o
);
    localparam logic [TS_W-1:0] ONE = {{(TS_W-1){1'b0}}, 1'b1};

    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ts_q <= '0;
        else if (we) ts_q <= wdata;
        else         ts_q <= ts_q + ONE;
    end

    assign ts_o   = ts_q;
    assign wrap_o = !we && (&ts_q);

endmodule

// File: rtl/ivt_status.sv
module ivt_status #(
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] set_i,
    input  logic              clr_we,
    input  logic [PEND_W-1:0] clr_mask,
    output logic [PEND_W-1:0] pend_o
);
    logic [PEND_W-1:0] pend_q, clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_eff) | set_i;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/stamp_interval_timer.sv
module stamp_interval_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_tmr1,
    output logic              irq_tmr2,
    output logic              irq_stamp
);
    localparam logic [ADDR_W-1:0] A_TS     = ADDR_W'(OFS_TS);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic [TS_W-1:0]                  ts_q;
    logic                             ts_wrap;
    logic [PEND_W-1:0]                pend_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]    cur_v, rcnt_v;
    logic [NUM_TMR-1:0][31:0]         rword_v;
    tmr_state_e [NUM_TMR-1:0]         st_v;
    logic [NUM_TMR-1:0]               expire_v;

    ivt_stamp #(.TS_W(TS_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we && (bus_addr == A_TS)),
        .wdata  (bus_wdata[TS_W-1:0]),
        .ts_o   (ts_q),
        .wrap_o (ts_wrap)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_T1_RLD + OFS_TMR_STEP * i);
        ivt_downcounter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .rld_we     (bus_we && (bus_addr == A_RLD)),
            .wdata      (bus_wdata),
            .cur_o      (cur_v[i]),
            .rld_cnt_o  (rcnt_v[i]),
            .rld_word_o (rword_v[i]),
            .state_o    (st_v[i]),
            .expire_o   (expire_v[i])
        );
    end

    ivt_status #(.PEND_W(PEND_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    ({ts_wrap, expire_v}),
        .clr_we   (bus_we && (bus_addr == A_STATUS)),
        .clr_mask (bus_wdata[PEND_W-1:0]),
        .pend_o   (pend_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_TS)     bus_rdata[TS_W-1:0]   = ts_q;
        if (bus_addr == A_STATUS) bus_rdata[PEND_W-1:0] = pend_q;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(OFS_T1_CUR + OFS_TMR_STEP * i))
                bus_rdata[CNT_W-1:0] = cur_v[i];
            if (bus_addr == ADDR_W'(OFS_T1_RLD + OFS_TMR_STEP * i))
                bus_rdata = rword_v[i];
        end
    end

    assign irq_tmr1  = pend_q[0];
    assign irq_tmr2  = pend_q[1];
    assign irq_stamp = pend_q[PEND_TS];

endmodule

// File: rtl/stamp_interval_timer_checker.sv
module stamp_interval_timer_checker
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32,
    parameter int TS_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [TS_W-1:0]               ts_q,
    input logic [PEND_W-1:0]             pend_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cur_v,
    input logic [NUM_TMR-1:0][CNT_W-1:0] rcnt_v,
    input tmr_state_e [NUM_TMR-1:0]      st_v,
    input logic                          irq_tmr1,
    input logic                          irq_tmr2,
    input logic                          irq_stamp
);
    localparam logic [ADDR_W-1:0] A_TS     = ADDR_W'(OFS_TS);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [TS_W-1:0]   TS_ONE   = {{(TS_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  C_ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

    logic ts_wr;
    assign ts_wr = bus_we && (bus_addr == A_TS);

    a_r1_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_wr |=> ts_q == $past(ts_q) + TS_ONE);

    a_r1_stamp_load: assert property (@(posedge clk) disable iff (!rst_n)
        ts_wr |=> ts_q == $past(bus_wdata[TS_W-1:0]));

    a_r2_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_wr && (&ts_q)) |=> irq_stamp);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_T1_RLD + OFS_TMR_STEP * i);
        logic rld_wr;
        assign rld_wr = bus_we && (bus_addr == A_RLD);

        a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (st_v[i] != ST_IDLE && cur_v[i] != '0) |=> cur_v[i] == $past(cur_v[i]) - C_ONE);

        a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (st_v[i] == ST_PERIODIC && cur_v[i] == '0) |=> (cur_v[i] == $past(rcnt_v[i])) && pend_q[i]);

        a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (st_v[i] == ST_ONESHOT && cur_v[i] == '0 && !rld_wr) |=> (st_v[i] == ST_IDLE) && pend_q[i]);

        a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (st_v[i] == ST_IDLE && !(rld_wr && bus_wdata[0])) |=> $stable(cur_v[i]));

        a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_STATUS && bus_wdata[i] && !(st_v[i] != ST_IDLE && cur_v[i] == '0))
            |=> !pend_q[i]);
    end

    // R10: interrupt lines track the pending flags from one clock to the next
    a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[0]) |-> irq_tmr1 && ($past(irq_tmr1) == 1'b0));

    a_r10_irq2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v[1] == ST_IDLE && !irq_tmr2 && !(bus_we && bus_addr == ADDR_W'(OFS_T1_RLD + OFS_TMR_STEP))) |=> !irq_tmr2);

endmodule

bind stamp_interval_timer stamp_interval_timer_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .TS_W   (TS_W)
) u_chk (.*);

// File: tb/stamp_interval_timer_bench.sv
`timescale 1ns/1ps
module stamp_interval_timer_bench;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 16;
    localparam int TS_W   = 8;

    localparam logic [5:0] A_TS = 6'h00, A_T1V = 6'h04, A_T1R = 6'h08,
                           A_T2V = 6'h0C, A_T2R = 6'h10, A_ST = 6'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_tmr1, irq_tmr2, irq_stamp;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    stamp_interval_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_stamp_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tmr1(irq_tmr1), .irq_tmr2(irq_tmr2), .irq_stamp(irq_stamp)
    );

    // {is_write, byte offset, write data or expected read data}
    localparam int NV = 16;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 6'h04, 32'h0000_1234},  // R11 write to value register
        {1'b0, 6'h04, 32'h0000_0000},
        {1'b1, 6'h08, 32'h0000_ABC6},  // R3 disabled, one-shot flag
        {1'b0, 6'h08, 32'h0000_ABC6},
        {1'b0, 6'h04, 32'h0000_0000},
        {1'b1, 6'h10, 32'hFFFF_FFFE},  // R3 zero-extension above CNT_W
        {1'b0, 6'h10, 32'h0000_FFFE},
        {1'b1, 6'h14, 32'hFFFF_FFFF},  // R11 unmapped write
        {1'b0, 6'h14, 32'h0000_0000},
        {1'b0, 6'h1C, 32'h0000_0000},
        {1'b0, 6'h09, 32'h0000_0000},  // R11 misaligned
        {1'b1, 6'h08, 32'h0000_0000},
        {1'b0, 6'h08, 32'h0000_0000},
        {1'b1, 6'h10, 32'h0000_0032},
        {1'b0, 6'h10, 32'h0000_0032},
        {1'b0, 6'h0C, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        wait_n(3);
        rst_n = 1'b1;
        // reset state
        chk("reset R10 irq lines", {29'd0, irq_stamp, irq_tmr2, irq_tmr1}, 32'd0);
        rd(A_T1R, v); chk("reset R3 reload word", v, 32'd0);
        rd(A_ST, v);  chk("reset R9 status", v, 32'd0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][38]) wr(VEC[k][37:32], VEC[k][31:0]);
            else begin
                rd(VEC[k][37:32], v);
                chk($sformatf("table R3 R11 vector %0d", k), v, VEC[k][31:0]);
            end
        end
        wr(A_T2R, 32'd0);

        // R4 R5 periodic, count 8
        wr(A_T1R, 32'h9);
        rd(A_T1V, v); chk("R4 start loads count", v, 32'd8);
        wait_n(8);
        rd(A_T1V, v); chk("R4 value reaches zero", v, 32'd0);
        chk("R4 no pending before expiry", {31'd0, irq_tmr1}, 32'd0);
        wait_n(1);
        chk("R4 R10 pending after count+1", {31'd0, irq_tmr1}, 32'd1);
        rd(A_T1V, v); chk("R5 reloaded", v, 32'd8);
        wr(A_ST, 32'h1);
        chk("R9 cleared by writing 1", {31'd0, irq_tmr1}, 32'd0);
        wait_n(7);
        chk("R5 no early second expiry", {31'd0, irq_tmr1}, 32'd0);
        wait_n(1);
        chk("R5 second periodic expiry", {31'd0, irq_tmr1}, 32'd1);
        wr(A_T1R, 32'h0);
        rd(A_T1V, v); wait_n(5); rd(A_T1V, v2);
        chk("R8 value frozen after stop", v2, v);
        wr(A_ST, 32'h1);

        // R6 one-shot, count 4
        wr(A_T2R, 32'h7);
        wait_n(4);
        chk("R6 no pending before expiry", {31'd0, irq_tmr2}, 32'd0);
        wait_n(1);
        chk("R6 pending on expiry", {31'd0, irq_tmr2}, 32'd1);
        rd(A_T2R, v); chk("R6 enable flag cleared", v, 32'h6);
        wr(A_ST, 32'h1);
        chk("R9 writing other bit leaves flag", {31'd0, irq_tmr2}, 32'd1);
        wr(A_ST, 32'h2);
        wait_n(20);
        chk("R6 no further expiry", {31'd0, irq_tmr2}, 32'd0);
        rd(A_T2V, v); chk("R6 value stays zero", v, 32'd0);

        // R7 rewrite while running
        wr(A_T1R, 32'h9);
        wait_n(2);
        wr(A_T1R, 32'h15);
        rd(A_T1V, v);  chk("R7 current value kept", v, 32'd5);
        rd(A_T1R, v);  chk("R7 reload word updated", v, 32'h15);
        wait_n(5);
        chk("R7 old schedule, not yet", {31'd0, irq_tmr1}, 32'd0);
        wait_n(1);
        chk("R7 expiry on old schedule", {31'd0, irq_tmr1}, 32'd1);
        rd(A_T1V, v);  chk("R7 new count loaded", v, 32'd20);
        wr(A_ST, 32'h1);
        wait_n(19);
        chk("R7 new period, not yet", {31'd0, irq_tmr1}, 32'd0);
        wait_n(1);
        chk("R7 new period expiry", {31'd0, irq_tmr1}, 32'd1);
        wr(A_T1R, 32'h0);
        wr(A_ST, 32'h1);

        // R9 set wins over same-clock clear
        wr(A_T1R, 32'h3);
        wr(A_ST, 32'h1);
        chk("R9 set wins over clear", {31'd0, irq_tmr1}, 32'd1);
        wr(A_ST, 32'h1);
        chk("R9 clear after collision", {31'd0, irq_tmr1}, 32'd0);

        // R1 R2 timestamp
        wr(A_TS, 32'h0);
        rd(A_TS, v); chk("R1 write 0 resets", v, 32'd0);
        wait_n(5);
        rd(A_TS, v); chk("R1 counts each clock", v, 32'd5);
        wr(A_TS, 32'hFFFF_FFF0);
        rd(A_TS, v); chk("R1 load, zero-extended", v, 32'h0000_00F0);
        wr(A_ST, 32'h4);
        wait_n(14);
        rd(A_TS, v); chk("R1 at all ones", v, 32'h0000_00FF);
        chk("R2 no flag before wrap", {31'd0, irq_stamp}, 32'd0);
        wait_n(1);
        chk("R2 R10 flag on wrap", {31'd0, irq_stamp}, 32'd1);
        rd(A_ST, v); chk("R2 status bit 2", v & 32'h7, 32'h4);
        wr(A_ST, 32'h4);
        chk("R9 timestamp flag cleared", {31'd0, irq_stamp}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule